// File: doc/BRIEF.md
# Configurable Edge and Level Interrupt Detector

This block watches eight input lines and raises an interrupt when any line shows a chosen event. Each line can fire on a rising edge, a falling edge, any transition, a high level or a low level. Three configuration bits per line select the event: a class bit, a polarity bit and an any-transition bit. The any-transition bit takes precedence over the other two. Inputs pass through a synchroniser and are sampled on a sample tick. The tick comes every clock in the default build. A parameter divides it down, so the same logic can run at a slow rate such as 32 kHz relative to its clock.

Software uses a 32-bit word-addressed register port. Writes take effect at the clock edge on which `regWr` is high. Reads are combinational from `regAddr`. Address bits [1:0] are ignored. The map is:

- 0x00: synchronised input levels (read only).
- 0x04: raw status.
- 0x08: masked status.
- 0x0C: write-one-to-clear; reads as 0.
- 0x10: enable.
- 0x14: class; 1 = level, 0 = edge.
- 0x18: polarity; 1 = rising or high, 0 = falling or low.
- 0x1C: any-transition.

Bit i of every register belongs to line i. Bits 31:8 read as zero.

Top module: `intr_trigger_det`

## Requirements
- R1: While reset is asserted and right after it, every register reads 0 and `irqOut` is 0. The zero configuration means falling-edge detection on every line, with every line disabled.
- R2: Register 0x00 returns in bits 7:0 the input levels after two synchroniser stages, so a change appears two clock edges after it is applied. Bits 31:8 read as 0.
- R3: With class 0 and any-transition 0, a line with polarity 1 sets its raw bit on a rising input and a line with polarity 0 sets it on a falling input. The opposite edge has no effect. The raw bit stays at 1 until it is cleared.
- R4: With any-transition 1, a line sets its raw bit on either edge, whatever its class and polarity bits hold. The bit stays set until cleared.
- R5: With class 1 and any-transition 0, a line's raw bit follows the level condition: input high for polarity 1, input low for polarity 0. It drops without a clear once the condition ends.
- R6: Writing 0x0C clears each raw bit whose data bit is 1 and leaves the bits written as 0 unchanged. A level line whose condition still holds reads 0 for one cycle and then sets again. An edge detected in the same cycle as the clear keeps its bit set.
- R7: Register 0x08 reads raw status AND enable. `irqOut` is 1 exactly when some masked bit is 1.
- R8: For the first three sample ticks after reset, no raw bit can be set. An input already high at reset therefore produces no edge, even on a line set to any-transition.
- R9: Writes to 0x00, 0x04 and 0x08 change nothing. Register 0x0C always reads 0. Configuration registers keep only bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register port and sampling |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | 5 | Byte address of the register |
| regWdata | input | 32 | Write data |
| chanIn | input | 8 | Monitored input lines |
| regRdata | output | 32 | Read data for `regAddr` |
| irqOut | output | 1 | Combined interrupt |

## Verification
A stuck or lost raw bit shows at the ports one cycle later, through register 0x04, register 0x08 and `irqOut`. The bench reads back after every stimulus, so such an error is caught in the next check. A false edge from the synchroniser's reset values would set a status bit about three cycles after reset, before any real stimulus is applied. A wrong decode of class, polarity or any-transition shows up as a status bit on the wrong input edge. The bench drives each line through both edges to expose that.

// File: rtl/trig_det_pkg.sv
package trig_det_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    IDX_LEVELS = 3'd0,
    IDX_RAW    = 3'd1,
    IDX_MASKED = 3'd2,
    IDX_CLEAR  = 3'd3,
    IDX_ENABLE = 3'd4,
    IDX_CLASS  = 3'd5,
    IDX_POL    = 3'd6,
    IDX_ANY    = 3'd7
  } regIdx_e;

  typedef struct packed {
    logic clrWr;
    logic sampleTick;
  } ctlStrobe_t;
endpackage

// File: rtl/trig_det_ctrl.sv
module trig_det_ctrl
  import trig_det_pkg::*;
#(
  parameter int CHANNELS   = 8,
  parameter int SAMPLE_DIV = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  input  logic [CHANNELS-1:0] rawStatus,
  input  logic [CHANNELS-1:0] maskedStatus,
  input  logic [CHANNELS-1:0] levels,
  output logic [DATA_W-1:0]   regRdata,
  output logic [CHANNELS-1:0] enableQ,
  output logic [CHANNELS-1:0] classQ,
  output logic [CHANNELS-1:0] polQ,
  output logic [CHANNELS-1:0] anyQ,
  output ctlStrobe_t          strobes
);
  regIdx_e regIdx;
  logic    unusedBits;

  assign regIdx     = regIdx_e'(regAddr[ADDR_W-1:2]);
  assign unusedBits = ^{regAddr[1:0], regWdata[DATA_W-1:CHANNELS]};

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      classQ  <= '0;
      polQ    <= '0;
      anyQ    <= '0;
    end else if (regWr) begin
      case (regIdx)
        IDX_ENABLE: enableQ <= regWdata[CHANNELS-1:0];
        IDX_CLASS:  classQ  <= regWdata[CHANNELS-1:0];
        IDX_POL:    polQ    <= regWdata[CHANNELS-1:0];
        IDX_ANY:    anyQ    <= regWdata[CHANNELS-1:0];
        default: ;
      endcase
    end
  end

  assign strobes.clrWr = regWr && (regIdx == IDX_CLEAR);

  // sample tick: every cycle, or a divided-down rate
  generate
    if (SAMPLE_DIV <= 1) begin : g_tick_full
      assign strobes.sampleTick = 1'b1;
    end else begin : g_tick_div
      localparam int TICK_W = $clog2(SAMPLE_DIV);
      logic [TICK_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          divCnt <= '0;
        end else if (divCnt == TICK_W'(SAMPLE_DIV - 1)) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      assign strobes.sampleTick = (divCnt == TICK_W'(SAMPLE_DIV - 1));
    end
  endgenerate

  // read mux
  always_comb begin
    regRdata = '0;
    case (regIdx)
      IDX_LEVELS: regRdata[CHANNELS-1:0] = levels;
      IDX_RAW:    regRdata[CHANNELS-1:0] = rawStatus;
      IDX_MASKED: regRdata[CHANNELS-1:0] = maskedStatus;
      IDX_CLEAR:  regRdata = '0;
      IDX_ENABLE: regRdata[CHANNELS-1:0] = enableQ;
      IDX_CLASS:  regRdata[CHANNELS-1:0] = classQ;
      IDX_POL:    regRdata[CHANNELS-1:0] = polQ;
      IDX_ANY:    regRdata[CHANNELS-1:0] = anyQ;
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/trig_det_path.sv
module trig_det_path
  import trig_det_pkg::*;
#(
  parameter int CHANNELS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobes,
  input  logic [CHANNELS-1:0] clrBits,
  input  logic [CHANNELS-1:0] classQ,
  input  logic [CHANNELS-1:0] polQ,
  input  logic [CHANNELS-1:0] anyQ,
  input  logic [CHANNELS-1:0] chanIn,
  output logic [CHANNELS-1:0] levels,
  output logic [CHANNELS-1:0] rawStatus,
  output logic [CHANNELS-1:0] edgeHit,
  output logic                armed
);
  localparam int WARM   = SYNC_STAGES + 1;
  localparam int WARM_W = $clog2(WARM + 1);

  logic [SYNC_STAGES-1:0][CHANNELS-1:0] syncQ;
  logic [CHANNELS-1:0] curQ, prevQ;
  logic [CHANNELS-1:0] riseVec, fallVec, levelHit, clrVec;
  logic [WARM_W-1:0]   warmCnt;

  // synchroniser, clocked on the sample tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= '0;
    end else if (strobes.sampleTick) begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], chanIn};
      prevQ <= curQ;
    end
  end

  assign curQ   = syncQ[SYNC_STAGES-1];
  assign levels = curQ;

  // warm-up: wait until the previous sample holds a real value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      warmCnt <= '0;
    end else if (strobes.sampleTick && !armed) begin
      warmCnt <= warmCnt + 1'b1;
    end
  end

  assign armed   = (warmCnt == WARM_W'(WARM));
  assign riseVec = curQ & ~prevQ;
  assign fallVec = ~curQ & prevQ;
  assign clrVec  = {CHANNELS{strobes.clrWr}} & clrBits;

  generate
    for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
      logic edgeSel;
      logic levelSel;

      assign edgeSel  = anyQ[i] ? (riseVec[i] | fallVec[i])
                               : (polQ[i] ? riseVec[i] : fallVec[i]);
      assign levelSel = polQ[i] ? curQ[i] : ~curQ[i];

      assign edgeHit[i]  = armed & strobes.sampleTick & edgeSel &
                           (anyQ[i] | ~classQ[i]);
      assign levelHit[i] = armed & levelSel & classQ[i] & ~anyQ[i];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          rawStatus[i] <= 1'b0;
        end else if (classQ[i] && !anyQ[i]) begin
          rawStatus[i] <= levelHit[i] & ~clrVec[i];
        end else begin
          rawStatus[i] <= (rawStatus[i] & ~clrVec[i]) | edgeHit[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/intr_trigger_det.sv
module intr_trigger_det
  import trig_det_pkg::*;
#(
  parameter int CHANNELS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_DIV  = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  input  logic [CHANNELS-1:0] chanIn,
  output logic [DATA_W-1:0]   regRdata,
  output logic                irqOut
);
  ctlStrobe_t          strobes;
  logic [CHANNELS-1:0] enableQ, classQ, polQ, anyQ;
  logic [CHANNELS-1:0] rawStatus, maskedStatus, levels, edgeHit;
  logic                armed;

  assign maskedStatus = rawStatus & enableQ;
  assign irqOut       = |maskedStatus;

  trig_det_ctrl #(
    .CHANNELS  (CHANNELS),
    .SAMPLE_DIV(SAMPLE_DIV)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWr       (regWr),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .rawStatus   (rawStatus),
    .maskedStatus(maskedStatus),
    .levels      (levels),
    .regRdata    (regRdata),
    .enableQ     (enableQ),
    .classQ      (classQ),
    .polQ        (polQ),
    .anyQ        (anyQ),
    .strobes     (strobes)
  );

  trig_det_path #(
    .CHANNELS   (CHANNELS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .clrBits  (regWdata[CHANNELS-1:0]),
    .classQ   (classQ),
    .polQ     (polQ),
    .anyQ     (anyQ),
    .chanIn   (chanIn),
    .levels   (levels),
    .rawStatus(rawStatus),
    .edgeHit  (edgeHit),
    .armed    (armed)
  );
endmodule

// File: rtl/trig_det_checker.sv
module trig_det_checker #(
  parameter int CHANNELS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                irqOut,
  input logic [CHANNELS-1:0] rawStatus,
  input logic [CHANNELS-1:0] enableQ,
  input logic [CHANNELS-1:0] classQ,
  input logic [CHANNELS-1:0] anyQ,
  input logic                clrWr,
  input logic [CHANNELS-1:0] clrBits,
  input logic [CHANNELS-1:0] edgeHit,
  input logic                armed
);
  logic [CHANNELS-1:0] stickyMask, clrVec;
  assign stickyMask = ~classQ | anyQ;
  assign clrVec     = {CHANNELS{clrWr}} & clrBits;

  // R7: interrupt output agrees with status and enable
  a_r7_irq_from_masked: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(rawStatus & enableQ));

  // R8: nothing is flagged before the warm-up ends
  a_r8_quiet_warmup: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (rawStatus == '0));

  // R3: edge status holds until a clear
  a_r3_edge_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(rawStatus) & $past(stickyMask) & stickyMask &
               ~$past(clrVec)) & ~rawStatus) == '0));

  // R6: a cleared bit is zero next cycle unless an edge arrived with it
  a_r6_clear_effect: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawStatus & $past(clrVec) & ~$past(edgeHit)) == '0));
endmodule

bind intr_trigger_det trig_det_checker #(.CHANNELS(CHANNELS)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .irqOut   (irqOut),
  .rawStatus(rawStatus),
  .enableQ  (enableQ),
  .classQ   (classQ),
  .anyQ     (anyQ),
  .clrWr    (strobes.clrWr),
  .clrBits  (regWdata[CHANNELS-1:0]),
  .edgeHit  (edgeHit),
  .armed    (armed)
);

// File: tb/test_intr_trigger_det.sv
module test_intr_trigger_det;
  localparam logic [4:0] A_LEVELS = 5'h00;
  localparam logic [4:0] A_RAW    = 5'h04;
  localparam logic [4:0] A_MASKED = 5'h08;
  localparam logic [4:0] A_CLEAR  = 5'h0C;
  localparam logic [4:0] A_ENABLE = 5'h10;
  localparam logic [4:0] A_CLASS  = 5'h14;
  localparam logic [4:0] A_POL    = 5'h18;
  localparam logic [4:0] A_ANY    = 5'h1C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [7:0]  chanIn = 8'hFF;
  logic [31:0] regRdata;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intr_trigger_det i_intr_trigger_det (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .chanIn(chanIn), .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", what, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(logic [4:0] a, logic [31:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic readReg(logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic expectReg(string what, logic [4:0] a, logic [31:0] exp);
    logic [31:0] v;
    readReg(a, v);
    check(what, v, exp);
  endtask

  task automatic setIn(logic [7:0] v);
    chanIn = v;
    waitCyc(4);
  endtask

  task automatic testReset();
    expectReg("R1 enable reset", A_ENABLE, 32'h0);
    expectReg("R1 class reset", A_CLASS, 32'h0);
    expectReg("R1 polarity reset", A_POL, 32'h0);
    expectReg("R1 any reset", A_ANY, 32'h0);
    expectReg("R1 raw reset", A_RAW, 32'h0);
    check("R1 irq reset", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testWarmup();
    @(negedge clk);
    rstN = 1'b1;
    writeReg(A_ANY, 32'hFF);
    waitCyc(10);
    expectReg("R8 no false edge after reset", A_RAW, 32'h0);
    expectReg("R2 levels readback", A_LEVELS, 32'hFF);
  endtask

  task automatic testLevelsTiming();
    chanIn = 8'h5F;
    @(negedge clk);
    expectReg("R2 levels one edge later unchanged", A_LEVELS, 32'hFF);
    @(negedge clk);
    expectReg("R2 levels two edges later", A_LEVELS, 32'h5F);
    writeReg(A_CLEAR, 32'hFF);
    chanIn = 8'hFF;
    waitCyc(4);
    writeReg(A_CLEAR, 32'hFF);
    expectReg("R2 status cleared", A_RAW, 32'h0);
  endtask

  task automatic testAnyEdge();
    setIn(8'hFE);
    expectReg("R4 any-edge fall", A_RAW, 32'h01);
    writeReg(A_CLEAR, 32'hFF);
    expectReg("R6 clear edge status", A_RAW, 32'h0);
    setIn(8'hFF);
    expectReg("R4 any-edge rise", A_RAW, 32'h01);
    writeReg(A_CLEAR, 32'hFF);
    writeReg(A_CLASS, 32'hFF);
    setIn(8'hFD);
    expectReg("R4 any-edge overrides level class", A_RAW, 32'h02);
    setIn(8'hFF);
    expectReg("R4 any-edge holds after level returns", A_RAW, 32'h02);
    writeReg(A_ANY, 32'h0);
    writeReg(A_CLASS, 32'h0);
    writeReg(A_CLEAR, 32'hFF);
    expectReg("R4 cleanup", A_RAW, 32'h0);
  endtask

  task automatic testEdges();
    writeReg(A_POL, 32'h04);
    setIn(8'hFB);
    expectReg("R3 falling ignored on rising line", A_RAW, 32'h0);
    setIn(8'hFF);
    expectReg("R3 rising edge detected", A_RAW, 32'h04);
    waitCyc(5);
    expectReg("R3 edge status held", A_RAW, 32'h04);
    setIn(8'hDF);
    expectReg("R3 falling edge detected", A_RAW, 32'h24);
    writeReg(A_CLEAR, 32'h04);
    expectReg("R6 zero bits untouched by clear", A_RAW, 32'h20);
    writeReg(A_CLEAR, 32'h20);
    setIn(8'hFF);
    expectReg("R3 rising ignored on falling line", A_RAW, 32'h0);
  endtask

  task automatic testLevels();
    writeReg(A_CLASS, 32'h0C);
    writeReg(A_POL, 32'h04);
    waitCyc(2);
    expectReg("R5 high level active", A_RAW, 32'h04);
    setIn(8'hF7);
    expectReg("R5 low level active", A_RAW, 32'h0C);
    setIn(8'hFF);
    expectReg("R5 level status follows input", A_RAW, 32'h04);
    writeReg(A_CLEAR, 32'h04);
    expectReg("R6 level cleared for one cycle", A_RAW, 32'h0);
    @(negedge clk);
    expectReg("R6 level sets again", A_RAW, 32'h04);
    setIn(8'hFB);
    expectReg("R5 level drops without clear", A_RAW, 32'h0);
  endtask

  task automatic testMask();
    writeReg(A_CLASS, 32'h0);
    writeReg(A_POL, 32'h0);
    writeReg(A_CLEAR, 32'hFF);
    writeReg(A_ENABLE, 32'hFFFFFF08);
    expectReg("R9 enable keeps low byte", A_ENABLE, 32'h08);
    setIn(8'hEB);
    expectReg("R7 raw unmasked", A_RAW, 32'h10);
    expectReg("R7 masked filters", A_MASKED, 32'h0);
    check("R7 irq low when masked", {31'b0, irqOut}, 32'h0);
    setIn(8'hE3);
    expectReg("R7 masked shows enabled", A_MASKED, 32'h08);
    check("R7 irq high", {31'b0, irqOut}, 32'h1);
    writeReg(A_CLEAR, 32'h08);
    check("R7 irq drops after clear", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testReadOnly();
    writeReg(A_RAW, 32'hFFFFFFFF);
    writeReg(A_MASKED, 32'hFFFFFFFF);
    writeReg(A_LEVELS, 32'h0);
    expectReg("R9 raw write ignored", A_RAW, 32'h10);
    expectReg("R9 levels write ignored", A_LEVELS, 32'hE3);
    expectReg("R9 clear reads zero", A_CLEAR, 32'h0);
    check("R9 irq unchanged", {31'b0, irqOut}, 32'h0);
  endtask

  initial begin
    waitCyc(5);
    testReset();
    testWarmup();
    testLevelsTiming();
    testAnyEdge();
    testEdges();
    testLevels();
    testMask();
    testReadOnly();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule